// File: doc/BRIEF.md
# Page-Boundary Transfer Interrupt Unit

This unit observes completed data transfers that land in a memory window divided into equal pages. It tracks the lower 32 pages of a 64-page window. A successful transfer that touches the final 32-bit word of one of those pages sets that page's sticky status bit. Each status bit has a mask bit, and an active-low interrupt line goes low while any unmasked status bit is set.

Software uses four word offsets. Offset 0 is the status register, which clears on a write of 1. Offset 1 sets mask bits and offset 2 clears them, and both read back the current mask. Offset 3 is reserved. The page size and the window base are parameters. The block contains no bus protocol, no address translation and no data path.

Top module: `pageIrqUnit`

## Requirements
- R1: After reset the status reads 0x00000000, the mask reads 0xFFFFFFFF and intN is 1.
- R2: If xferValid=1 and xferOk=1 and xferAddr lies in window page k (0..31) with address bits [log2(PAGE_BYTES)-1:2] all ones (the last Dword), status bit k reads 1 from the next clock edge on. Bit 0 is the lowest-addressed page.
- R3: A transfer with xferOk=0, an address that is not the last Dword of its page, or an address outside the lower 32 pages (including the upper 32 pages and addresses below WIN_BASE) leaves the status unchanged.
- R4: A write to offset 0 clears each status bit whose write-data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R5: A write to offset 1 sets each mask bit whose data bit is 1 and leaves the others unchanged. A read of offset 1 returns the mask.
- R6: A write to offset 2 clears each mask bit whose data bit is 1 and leaves the others unchanged. A read of offset 2 returns the mask.
- R7: intN is 0 exactly when some status bit is 1 and its mask bit is 0. It follows the register state after the same clock edge.
- R8: When a hardware set and a clear from offset 0 hit the same status bit at the same edge, the bit becomes 1.
- R9: Offset 3 reads as 0, and writes to it change nothing.
- R10: regRdata is combinational on regAddr. Offset 0 returns the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferValid | input | 1 | A transfer completes this cycle |
| xferOk | input | 1 | The completing transfer succeeded |
| xferAddr | input | ADDR_W | Byte address of the transfer |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr |
| intN | output | 1 | Active-low interrupt |

## Verification
Every state change is due one clock edge after the input is applied. A status set, a status clear and a mask change all appear after that single edge. Read data and intN are combinational on the registers and on regAddr, so they are due in the same cycle as the state they reflect. The bench applies inputs on the falling edge and compares regRdata and intN with its model 1 ns later. After the comparison it advances the model as the design will advance at the next rising edge, so each result is checked in the first cycle it is due.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PAGE_CNT = 32;
  localparam int IDX_W = $clog2(PAGE_CNT);

  typedef enum logic [1:0] {
    OFS_STATUS = 2'd0,
    OFS_MSET   = 2'd1,
    OFS_MCLR   = 2'd2,
    OFS_RSVD   = 2'd3
  } regOfs_t;

  typedef struct packed {
    logic             hitValid;
    logic [IDX_W-1:0] pageIdx;
    logic             statusClr;
    logic             maskSet;
    logic             maskClr;
    regOfs_t          rdSel;
  } pitStrobes_t;
endpackage

// File: rtl/pitCtrl.sv
module pitCtrl
  import pit_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_BYTES = 4096,
  parameter logic [31:0] WIN_BASE   = 32'h0010_0000
) (
  input  logic              xferValid,
  input  logic              xferOk,
  input  logic [ADDR_W-1:0] xferAddr,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  output pitStrobes_t       strobes
);
  localparam int PAGE_LG = $clog2(PAGE_BYTES);
  localparam int WIN_LG  = PAGE_LG + IDX_W + 1;
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(WIN_BASE);

  logic inWindow;
  logic inLowerHalf;
  logic lastDword;

  generate
    if (WIN_LG < ADDR_W) begin : g_tagCmp
      assign inWindow = (xferAddr[ADDR_W-1:WIN_LG] == BASE_W[ADDR_W-1:WIN_LG]);
    end else begin : g_fullWin
      assign inWindow = 1'b1;
    end
  endgenerate

  assign inLowerHalf = ~xferAddr[WIN_LG-1];
  assign lastDword   = &xferAddr[PAGE_LG-1:2];

  always_comb begin
    strobes.hitValid  = xferValid & xferOk & inWindow & inLowerHalf & lastDword;
    strobes.pageIdx   = xferAddr[PAGE_LG+IDX_W-1:PAGE_LG];
    strobes.rdSel     = regOfs_t'(regAddr);
    strobes.statusClr = regWe & (regOfs_t'(regAddr) == OFS_STATUS);
    strobes.maskSet   = regWe & (regOfs_t'(regAddr) == OFS_MSET);
    strobes.maskClr   = regWe & (regOfs_t'(regAddr) == OFS_MCLR);
  end
endmodule

// File: rtl/pitDatapath.sv
module pitDatapath
  import pit_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  pitStrobes_t         strobes,
  input  logic [31:0]         regWdata,
  output logic [PAGE_CNT-1:0] statusVec,
  output logic [PAGE_CNT-1:0] maskVec,
  output logic [31:0]         regRdata,
  output logic                intN
);
  logic [PAGE_CNT-1:0] setVec;
  logic [PAGE_CNT-1:0] clrVec;
  logic [PAGE_CNT-1:0] wrBits;

  assign wrBits = regWdata[PAGE_CNT-1:0];

  generate
    for (genvar i = 0; i < PAGE_CNT; i++) begin : g_page
      assign setVec[i] = strobes.hitValid & (strobes.pageIdx == IDX_W'(i));
    end
  endgenerate

  assign clrVec = strobes.statusClr ? wrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusVec <= '0;
      maskVec   <= '1;
    end else begin
      statusVec <= (statusVec & ~clrVec) | setVec;
      if (strobes.maskSet)      maskVec <= maskVec | wrBits;
      else if (strobes.maskClr) maskVec <= maskVec & ~wrBits;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (strobes.rdSel)
      OFS_STATUS: regRdata[PAGE_CNT-1:0] = statusVec;
      OFS_MSET,
      OFS_MCLR:   regRdata[PAGE_CNT-1:0] = maskVec;
      default:    regRdata = '0;
    endcase
  end

  assign intN = ~|(statusVec & ~maskVec);
endmodule

// File: rtl/pageIrqUnit.sv
module pageIrqUnit
  import pit_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_BYTES = 4096,
  parameter logic [31:0] WIN_BASE   = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferValid,
  input  logic              xferOk,
  input  logic [ADDR_W-1:0] xferAddr,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              intN
);
  pitStrobes_t         strobes;
  logic [PAGE_CNT-1:0] statusVec;
  logic [PAGE_CNT-1:0] maskVec;

  pitCtrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WIN_BASE(WIN_BASE)) uCtrl (
    .xferValid(xferValid), .xferOk(xferOk), .xferAddr(xferAddr),
    .regWe(regWe), .regAddr(regAddr), .strobes(strobes)
  );

  pitDatapath uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWdata(regWdata),
    .statusVec(statusVec), .maskVec(maskVec), .regRdata(regRdata), .intN(intN)
  );
endmodule

// File: rtl/pitChecker.sv
module pitChecker #(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_BYTES = 4096,
  parameter logic [31:0] WIN_BASE   = 32'h0010_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferValid,
  input logic              xferOk,
  input logic [ADDR_W-1:0] xferAddr,
  input logic              regWe,
  input logic [1:0]        regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              intN,
  input logic [31:0]       statusVec,
  input logic [31:0]       maskVec
);
  localparam int PAGE_LG = $clog2(PAGE_BYTES);
  logic [ADDR_W-1:0] offs;
  logic              hit;
  logic [4:0]        hitIdx;

  assign offs   = xferAddr - ADDR_W'(WIN_BASE);
  assign hit    = xferValid && xferOk && (xferAddr >= ADDR_W'(WIN_BASE))
                  && (offs[ADDR_W-1:PAGE_LG+5] == '0) && (&offs[PAGE_LG-1:2]);
  assign hitIdx = offs[PAGE_LG+4:PAGE_LG];

  // R2 and R8: a qualifying hit always leaves its bit set, even with a clear at the same edge
  p_hit_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> statusVec[$past(hitIdx)]);
  p_no_change_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!hit && !(regWe && regAddr == 2'd0)) |=> $stable(statusVec));
  p_status_w1c_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd0 && !hit) |=> ((statusVec & $past(regWdata)) == 32'd0));
  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd1) |=> ((maskVec & $past(regWdata)) == $past(regWdata)));
  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd2) |=> ((maskVec & $past(regWdata)) == 32'd0));
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> (statusVec != 32'd0 && maskVec != 32'hFFFF_FFFF));
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && (regAddr == 2'd1 || regAddr == 2'd2)) |=> $stable(maskVec));
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (regRdata == 32'd0));
endmodule

bind pageIrqUnit pitChecker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WIN_BASE(WIN_BASE)) uChk (
  .clk(clk), .rstN(rstN), .xferValid(xferValid), .xferOk(xferOk), .xferAddr(xferAddr),
  .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
  .intN(intN), .statusVec(statusVec), .maskVec(maskVec)
);

// File: tb/sim_pageIrqUnit.sv
`timescale 1ns/1ps
module sim_pageIrqUnit;
  localparam int          ADDR_W = 32;
  localparam int          PAGE   = 4096;
  localparam logic [31:0] BASE   = 32'h0010_0000;

  logic        clk = 0;
  logic        rstN = 0;
  logic        xferValid = 0, xferOk = 0, regWe = 0;
  logic [31:0] xferAddr = 0, regWdata = 0;
  logic [1:0]  regAddr = 0;
  logic [31:0] regRdata;
  logic        intN;

  int total = 0, bad = 0;
  logic [31:0] mStatus = 0, mMask = 32'hFFFF_FFFF;

  always #5 clk = ~clk;

  pageIrqUnit #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .WIN_BASE(BASE)) u0 (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .xferOk(xferOk), .xferAddr(xferAddr),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .intN(intN)
  );

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mStatus;
      2'd1, 2'd2: return mMask;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: apply inputs, compare against model, then advance model over the coming edge
  task automatic step(input string req, input logic xv, input logic xo, input logic [31:0] xa,
                      input logic we, input logic [1:0] ra, input logic [31:0] wd);
    longint off;
    logic [31:0] setV;
    @(negedge clk);
    xferValid = xv; xferOk = xo; xferAddr = xa; regWe = we; regAddr = ra; regWdata = wd;
    #1;
    check(req, regRdata, expRead(ra));
    check("R7", {31'd0, intN}, {31'd0, ((mStatus & ~mMask) == 0)});
    off = longint'(xa) - longint'(BASE);
    setV = 0;
    if (xv && xo && off >= 0 && off < 32 * PAGE && (off % PAGE) >= PAGE - 4)
      setV = 32'd1 << (off / PAGE);
    if (we && ra == 2'd0) mStatus = mStatus & ~wd;
    mStatus = mStatus | setV;
    if (we && ra == 2'd1) mMask = mMask | wd;
    if (we && ra == 2'd2) mMask = mMask & ~wd;
  endtask

  task automatic idle(input string req, input logic [1:0] ra);
    step(req, 0, 0, 0, 0, ra, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    idle("R1", 0); idle("R1", 1); idle("R1", 2);
    // R2: last Dword of pages 0, 31 (byte 3 of word), 5
    step("R2", 1, 1, BASE + PAGE - 4, 0, 0, 0);
    step("R2", 1, 1, BASE + 32 * PAGE - 1, 0, 0, 0);
    step("R2", 1, 1, BASE + 6 * PAGE - 4, 0, 0, 0);
    idle("R10", 0);
    // R3: non-last word, upper half, below base, failed
    step("R3", 1, 1, BASE + 7 * PAGE, 0, 0, 0);
    step("R3", 1, 1, BASE + 7 * PAGE - 8, 0, 0, 0);
    step("R3", 1, 1, BASE + 33 * PAGE - 4, 0, 0, 0);
    step("R3", 1, 1, BASE - 4, 0, 0, 0);
    step("R3", 1, 0, BASE + 9 * PAGE - 4, 0, 0, 0);
    step("R3", 0, 1, BASE + 10 * PAGE - 4, 0, 0, 0);
    idle("R3", 0);
    // R6/R7: unmask page 0 and page 3
    step("R6", 0, 0, 0, 1, 2, 32'h0000_0009);
    idle("R6", 2); idle("R7", 0);
    // R5: remask page 0, zero write has no effect
    step("R5", 0, 0, 0, 1, 1, 32'h0000_0001);
    step("R5", 0, 0, 0, 1, 1, 32'h0);
    idle("R5", 1);
    step("R6", 0, 0, 0, 1, 2, 32'hFFFF_FFFF);
    idle("R6", 2);
    // R4: partial clear, zero write
    step("R4", 0, 0, 0, 1, 0, 32'h0000_0020);
    step("R4", 0, 0, 0, 1, 0, 32'h0);
    idle("R4", 0);
    // R8: set and clear together on page 2
    step("R8", 1, 1, BASE + 3 * PAGE - 4, 1, 0, 32'h0000_0004);
    idle("R8", 0);
    step("R8", 1, 1, BASE + 3 * PAGE - 4, 1, 0, 32'hFFFF_FFFF);
    idle("R8", 0);
    // R9: reserved offset
    step("R9", 0, 0, 0, 1, 3, 32'hFFFF_FFFF);
    idle("R9", 3); idle("R9", 0); idle("R9", 1);
    step("R4", 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
    idle("R4", 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = BASE - 4 * PAGE + ($urandom % (72 * PAGE));
      if ($urandom % 2) a = a | (PAGE - 4);
      step("R10", ($urandom % 3) != 0, ($urandom % 5) != 0, a,
           ($urandom % 3) == 0, 2'($urandom), $urandom);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule